// File: doc/BRIEF.md
# Sensor Gate Pulse Generator

This block produces the vertical sensor-gate pulses that transfer charge during a readout field. A field sequencer supplies the current line and pixel counts; the block compares them against programmed settings and drives a bus of gate outputs. Pulses only appear on a chosen active line, or on an optional repeat line. On those lines, each output is high for a pixel window that it takes from one of two programmable toggle pairs.

A per-output select word chooses the pair for each gate. A per-output mask word silences any gate on its own. The gate bus is registered, so it lags the pixel count by one clock. A two-stage synchronizer releases the asynchronous active-low reset on a clock edge.

Top module: `sgp_gate_gen`

## Requirements
- R1: The gate bus has 24 bits. Bit i of `pair_sel` and bit i of `gate_mask` control only `gate_o[i]`, where bit 0 is the first output and bit 23 is the last.
- R2: When `pair_sel[i]` is 0, output i takes its window from `tog_a_rise` and `tog_a_fall`. When `pair_sel[i]` is 1, it takes its window from `tog_b_rise` and `tog_b_fall`.
- R3: When `gate_mask[i]` is 1, `gate_o[i]` stays low. When it is 0, the output may pulse.
- R4: On any line other than the active lines, every gate output is low.
- R5: When `line_cnt` equals `act_line_rpt`, the gates pulse exactly as they do on the line given by `act_line_pri`.
- R6: If `act_line_rpt` equals `act_line_pri`, or holds the all-ones value 8191, no extra line pulses. In the all-ones case, line 8191 stays low unless it is the primary line.
- R7: The window is high when rise <= pixel < fall. The rise position is inclusive and the fall position is exclusive. If rise >= fall, the output never pulses.
- R8: `gate_o` reflects the inputs sampled at the previous rising clock edge, a latency of one cycle. It does not change between edges.
- R9: While `rst_n` is low, `gate_o` is all zeros, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_cnt | input | 13 | Current line number in the field |
| pix_cnt | input | 13 | Current pixel number in the line |
| tog_a_rise | input | 13 | Pair A rise position |
| tog_a_fall | input | 13 | Pair A fall position |
| tog_b_rise | input | 13 | Pair B rise position |
| tog_b_fall | input | 13 | Pair B fall position |
| pair_sel | input | 24 | Per-output pair select, 0 = A, 1 = B |
| gate_mask | input | 24 | Per-output mask, 1 = suppress |
| act_line_pri | input | 13 | Primary active line |
| act_line_rpt | input | 13 | Repeat active line; 8191 disables it |
| gate_o | output | 24 | Registered gate bus |

## Verification
The hardest case to reach from the ports is the repeat-line decode at its edges. These are a repeat line that coincides with the primary line, and a repeat line parked at all-ones while the line count actually reaches 8191. The stimulus drives the line count straight to those values and sweeps the pixel count across both windows, so both the off state and the duplicate-match state are observed. Narrow and inverted windows, together with one-hot select and mask words on the end bits, expose any mix-up in bit ordering or pair selection.

// File: rtl/sgp_pkg.sv
package sgp_pkg;
  localparam int unsigned GATE_N_DEF = 24;
  localparam int unsigned CNT_W_DEF  = 13;
  localparam int unsigned PAIR_N     = 2;

  typedef enum logic {
    PAIR_A = 1'b0,
    PAIR_B = 1'b1
  } pair_e;
endpackage

// File: rtl/sgp_rst_sync.sv
module sgp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/sgp_line_gate.sv
module sgp_line_gate #(
  parameter int unsigned CNT_W = 13
) (
  input  logic [CNT_W-1:0] line_cnt,
  input  logic [CNT_W-1:0] act_line_pri,
  input  logic [CNT_W-1:0] act_line_rpt,
  output logic             line_on
);
  localparam logic [CNT_W-1:0] RPT_OFF = {CNT_W{1'b1}};

  logic hit_pri;
  logic hit_rpt;

  always_comb begin
    hit_pri = (line_cnt == act_line_pri);
    hit_rpt = (act_line_rpt != RPT_OFF) && (line_cnt == act_line_rpt);
    line_on = hit_pri | hit_rpt;
  end
endmodule

// File: rtl/sgp_pix_window.sv
module sgp_pix_window #(
  parameter int unsigned CNT_W = 13
) (
  input  logic [CNT_W-1:0] pix_cnt,
  input  logic [CNT_W-1:0] rise_pos,
  input  logic [CNT_W-1:0] fall_pos,
  output logic             in_win
);
  logic past_rise;
  logic before_fall;

  always_comb begin
    past_rise   = (pix_cnt >= rise_pos);
    before_fall = (pix_cnt < fall_pos);
    in_win      = past_rise & before_fall;
  end
endmodule

// File: rtl/sgp_gate_lane.sv
module sgp_gate_lane
  import sgp_pkg::*;
#(
  parameter int unsigned PAIRS = PAIR_N
) (
  input  logic [PAIRS-1:0] win_vec,
  input  logic             sel,
  input  logic             mask,
  input  logic             line_on,
  output logic             gate_d
);
  pair_e pick;
  logic  win_sel;

  always_comb begin
    pick    = pair_e'(sel);
    win_sel = (pick == PAIR_B) ? win_vec[1] : win_vec[0];
    gate_d  = line_on & ~mask & win_sel;
  end
endmodule

// File: rtl/sgp_gate_gen.sv
module sgp_gate_gen
  import sgp_pkg::*;
#(
  parameter int unsigned GATE_N = GATE_N_DEF,
  parameter int unsigned CNT_W  = CNT_W_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  line_cnt,
  input  logic [CNT_W-1:0]  pix_cnt,
  input  logic [CNT_W-1:0]  tog_a_rise,
  input  logic [CNT_W-1:0]  tog_a_fall,
  input  logic [CNT_W-1:0]  tog_b_rise,
  input  logic [CNT_W-1:0]  tog_b_fall,
  input  logic [GATE_N-1:0] pair_sel,
  input  logic [GATE_N-1:0] gate_mask,
  input  logic [CNT_W-1:0]  act_line_pri,
  input  logic [CNT_W-1:0]  act_line_rpt,
  output logic [GATE_N-1:0] gate_o
);
  localparam int unsigned PAIRS = PAIR_N;

  logic                  rst_sync_n;
  logic                  line_on;
  logic [CNT_W-1:0]      rise_arr [PAIRS];
  logic [CNT_W-1:0]      fall_arr [PAIRS];
  logic [PAIRS-1:0]      win_vec;
  logic [GATE_N-1:0]     gate_d;
  logic [GATE_N-1:0]     gate_q;
  logic                  gate_en;

  sgp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sgp_line_gate #(.CNT_W(CNT_W)) u_line_gate (
    .line_cnt     (line_cnt),
    .act_line_pri (act_line_pri),
    .act_line_rpt (act_line_rpt),
    .line_on      (line_on)
  );

  always_comb begin
    rise_arr[0] = tog_a_rise;
    fall_arr[0] = tog_a_fall;
    rise_arr[1] = tog_b_rise;
    fall_arr[1] = tog_b_fall;
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_win
    sgp_pix_window #(.CNT_W(CNT_W)) u_win (
      .pix_cnt  (pix_cnt),
      .rise_pos (rise_arr[p]),
      .fall_pos (fall_arr[p]),
      .in_win   (win_vec[p])
    );
  end

  for (genvar g = 0; g < GATE_N; g++) begin : g_lane
    sgp_gate_lane #(.PAIRS(PAIRS)) u_lane (
      .win_vec (win_vec),
      .sel     (pair_sel[g]),
      .mask    (gate_mask[g]),
      .line_on (line_on),
      .gate_d  (gate_d[g])
    );
  end

  // The register only needs to load while on an active line or while
  // still holding a pulse to clear; elsewhere the next value is zero anyway.
  always_comb begin
    gate_en = line_on | (|gate_q);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  gate_q <= '0;
    else if (gate_en) gate_q <= gate_d;
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/sgp_gate_gen_chk.sv
module sgp_gate_gen_chk #(
  parameter int unsigned GATE_N = 24,
  parameter int unsigned CNT_W  = 13
) (
  input logic              clk,
  input logic              rst_ok_n,
  input logic [CNT_W-1:0]  line_cnt,
  input logic [CNT_W-1:0]  pix_cnt,
  input logic [CNT_W-1:0]  tog_a_rise,
  input logic [CNT_W-1:0]  tog_a_fall,
  input logic [CNT_W-1:0]  tog_b_rise,
  input logic [CNT_W-1:0]  tog_b_fall,
  input logic [GATE_N-1:0] pair_sel,
  input logic [GATE_N-1:0] gate_mask,
  input logic [CNT_W-1:0]  act_line_pri,
  input logic [CNT_W-1:0]  act_line_rpt,
  input logic [GATE_N-1:0] gate_o
);
  logic on_ref;
  assign on_ref = (line_cnt == act_line_pri) ||
                  ((line_cnt == act_line_rpt) && (act_line_rpt != {CNT_W{1'b1}}));

  // R3: masked outputs stay low
  p_mask_low_r3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    1'b1 |=> ((gate_o & $past(gate_mask)) == '0));

  // R4 / R6: nothing pulses off the active lines
  p_offline_low_r4: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !on_ref |=> (gate_o == '0));

  for (genvar g = 0; g < GATE_N; g++) begin : g_bit
    // R2 / R8: pair A window drives the bit one cycle later
    p_pair_a_r2: assert property (@(posedge clk) disable iff (!rst_ok_n)
      (on_ref && !gate_mask[g] && !pair_sel[g] &&
       pix_cnt >= tog_a_rise && pix_cnt < tog_a_fall) |=> gate_o[g]);

    // R2 / R8: pair B window drives the bit one cycle later
    p_pair_b_r2: assert property (@(posedge clk) disable iff (!rst_ok_n)
      (on_ref && !gate_mask[g] && pair_sel[g] &&
       pix_cnt >= tog_b_rise && pix_cnt < tog_b_fall) |=> gate_o[g]);

    // R7: fall position is exclusive
    p_fall_excl_r7: assert property (@(posedge clk) disable iff (!rst_ok_n)
      (pix_cnt == (pair_sel[g] ? tog_b_fall : tog_a_fall)) |=> !gate_o[g]);
  end
endmodule

bind sgp_gate_gen sgp_gate_gen_chk #(.GATE_N(GATE_N), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_ok_n     (rst_sync_n),
  .line_cnt     (line_cnt),
  .pix_cnt      (pix_cnt),
  .tog_a_rise   (tog_a_rise),
  .tog_a_fall   (tog_a_fall),
  .tog_b_rise   (tog_b_rise),
  .tog_b_fall   (tog_b_fall),
  .pair_sel     (pair_sel),
  .gate_mask    (gate_mask),
  .act_line_pri (act_line_pri),
  .act_line_rpt (act_line_rpt),
  .gate_o       (gate_o)
);

// File: tb/test_sgp_gate_gen.sv
module test_sgp_gate_gen;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [12:0] line_cnt, pix_cnt;
  logic [12:0] tog_a_rise, tog_a_fall, tog_b_rise, tog_b_fall;
  logic [23:0] pair_sel, gate_mask;
  logic [12:0] act_line_pri, act_line_rpt;
  logic [23:0] gate_o;

  int    checks = 0;
  int    failures = 0;
  int    cyc = 0;
  string cur_req = "R9";
  logic [23:0] exp_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  sgp_gate_gen i_sgp_gate_gen (
    .clk(clk), .rst_n(rst_n), .line_cnt(line_cnt), .pix_cnt(pix_cnt),
    .tog_a_rise(tog_a_rise), .tog_a_fall(tog_a_fall),
    .tog_b_rise(tog_b_rise), .tog_b_fall(tog_b_fall),
    .pair_sel(pair_sel), .gate_mask(gate_mask),
    .act_line_pri(act_line_pri), .act_line_rpt(act_line_rpt),
    .gate_o(gate_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > MAX_CYC) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [23:0] model();
    logic [23:0] r = '0;
    int ln = line_cnt;
    int px = pix_cnt;
    bit on = (ln == act_line_pri) || (ln == act_line_rpt && act_line_rpt != 13'd8191);
    for (int i = 0; i < 24; i++) begin
      int lo = pair_sel[i] ? int'(tog_b_rise) : int'(tog_a_rise);
      int hi = pair_sel[i] ? int'(tog_b_fall) : int'(tog_a_fall);
      r[i] = on && !gate_mask[i] && px >= lo && px < hi;
    end
    return r;
  endfunction

  task automatic check(input logic [23:0] act, input logic [23:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s line=%0d pix=%0d got=%h exp=%h", cur_req, line_cnt, pix_cnt, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    exp_q = model();
    @(negedge clk);
    check(gate_o, exp_q);
  endtask

  task automatic sweep(input int ln, input int p0, input int p1);
    line_cnt = 13'(ln);
    for (int p = p0; p <= p1; p++) begin
      pix_cnt = 13'(p);
      step();
    end
  endtask

  initial begin
    rst_n = 1'b0;
    tog_a_rise = 13'd5;  tog_a_fall = 13'd12;
    tog_b_rise = 13'd20; tog_b_fall = 13'd30;
    pair_sel = 24'h000000; gate_mask = 24'h000000;
    act_line_pri = 13'd100; act_line_rpt = 13'd8191;
    line_cnt = 13'd100; pix_cnt = 13'd6;
    // R9: reset holds outputs low even with an active window
    cur_req = "R9";
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(gate_o, 24'h0);
    end
    line_cnt = 13'd0;
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) step();

    // R2 / R7: alternating pair selection, full sweep over both windows
    cur_req = "R2";
    pair_sel = 24'hAAAAAA;
    sweep(100, 0, 40);
    pair_sel = 24'h555555;
    sweep(100, 0, 40);

    // R3: mask subsets
    cur_req = "R3";
    pair_sel = 24'h0F0F0F; gate_mask = 24'h00F00F;
    sweep(100, 0, 40);
    gate_mask = 24'hFFFFFF;
    sweep(100, 0, 40);

    // R1: end bits controlled individually
    cur_req = "R1";
    pair_sel = 24'h800000; gate_mask = 24'h7FFFFE;
    sweep(100, 0, 40);
    pair_sel = 24'h000001; gate_mask = 24'h7FFFFE;
    sweep(100, 0, 40);

    // R4: neighbouring lines stay quiet
    cur_req = "R4";
    pair_sel = 24'h00FF00; gate_mask = 24'h0;
    sweep(99, 0, 40);
    sweep(101, 0, 40);

    // R5: repeat line duplicates the pulses
    cur_req = "R5";
    act_line_rpt = 13'd200;
    sweep(200, 0, 40);
    sweep(201, 0, 40);

    // R6: repeat equal to primary, and repeat parked at all-ones
    cur_req = "R6";
    act_line_rpt = 13'd100;
    sweep(100, 0, 40);
    act_line_rpt = 13'd8191;
    sweep(8191, 0, 40);
    sweep(200, 0, 40);

    // R7: empty and inverted windows, plus edge pixels
    cur_req = "R7";
    tog_a_rise = 13'd15; tog_a_fall = 13'd15;
    tog_b_rise = 13'd25; tog_b_fall = 13'd10;
    pair_sel = 24'hF0F0F0;
    sweep(100, 0, 40);
    tog_a_rise = 13'd0; tog_a_fall = 13'd1;
    tog_b_rise = 13'd8190; tog_b_fall = 13'd8191;
    sweep(100, 0, 3);
    sweep(100, 8188, 8191);

    // R8: output does not move before the clock edge
    cur_req = "R8";
    tog_a_rise = 13'd5; tog_a_fall = 13'd12;
    pair_sel = 24'h0; gate_mask = 24'h0;
    line_cnt = 13'd100; pix_cnt = 13'd4;
    step();
    pix_cnt = 13'd5;
    #1;
    check(gate_o, 24'h000000);
    step();
    check(gate_o, 24'hFFFFFF);
    pix_cnt = 13'd12;
    #1;
    check(gate_o, 24'hFFFFFF);
    step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule